// File: doc/BRIEF.md
# B2 Error-Rate Defect Monitor

This block sits behind a SONET line-overhead receiver and turns per-frame B2 parity error counts into two defect flags: Signal Degrade (SD) and Signal Failure (SF). In STS-3 operation the incoming counts are BIP-24 errors rather than byte errors, but the block only sees a count. Errors are summed over windows whose length is a number of 1 ms ticks. Each defect has its own declaration window and threshold, and its own clearance window and threshold.

An inactive defect is declared at the end of a declaration window whose total is strictly above the declaration threshold. An active defect is cleared at the end of a clearance window whose total is strictly below the clearance threshold. Each evaluation uses one full window. Every flag change produces a one-cycle interrupt pulse. The host-bus registers, the B2 computation and the framing all sit outside this block. They drive the configuration inputs directly.

Top module: `b2_defect_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sd_defect`, `sf_defect`, `sd_irq` and `sf_irq` are all 0.
- R2: An inactive SD flag rises at the end of a declaration window whose error total is strictly greater than `sd_decl_thr`. A total equal to or below the threshold leaves it at 0.
- R3: An active SD flag falls at the end of a clearance window whose error total is strictly less than `sd_clr_thr`. A total equal to or above the threshold keeps it at 1.
- R4: SF follows the same declaration and clearance rules, using only `sf_decl_win`, `sf_decl_thr`, `sf_clr_win` and `sf_clr_thr`.
- R5: A window of N ms ends on the Nth `ms_tick` after it starts. The flag changes on the clock edge that samples that tick, and not before. An error count presented in the same cycle as the ending tick belongs to the ending window.
- R6: A window length of 0 disables the window. The flag holds its value, and errors and ticks have no effect on it.
- R7: The accumulator saturates at all ones (`ACC_W` bits) and does not wrap. It restarts from zero after each window boundary.
- R8: Each flag change raises the matching irq output for exactly one cycle, in the same cycle as the new flag value.
- R9: A change to a window length written in the middle of a window does not shorten or lengthen that window. It applies from the next window.
- R10: SD and SF are evaluated independently. Activity on one never changes the other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Per-frame error count strobe |
| err_count | input | CNT_W | B2/BIP error count for the frame |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| sd_decl_win | input | WIN_W | SD declaration window, ms (0 = off) |
| sd_decl_thr | input | ACC_W | SD declaration threshold |
| sd_clr_win | input | WIN_W | SD clearance window, ms (0 = off) |
| sd_clr_thr | input | ACC_W | SD clearance threshold |
| sf_decl_win | input | WIN_W | SF declaration window, ms (0 = off) |
| sf_decl_thr | input | ACC_W | SF declaration threshold |
| sf_clr_win | input | WIN_W | SF clearance window, ms (0 = off) |
| sf_clr_thr | input | ACC_W | SF clearance threshold |
| sd_defect | output | 1 | Signal Degrade flag |
| sf_defect | output | 1 | Signal Failure flag |
| sd_irq | output | 1 | One-cycle pulse on SD change |
| sf_irq | output | 1 | One-cycle pulse on SF change |

## Verification
The hardest case to reach from the ports is the saturation boundary. A wrapping accumulator and a saturating one only differ after more than 65535 errors in a single window. The stimulus raises the SD declaration threshold to 65534 and feeds several thousand maximum-count frames into a 1 ms window, which declares SD only if the sum saturates. It then feeds a total that would wrap to a value below a clearance threshold of 5, and checks that SD stays active. Window-length changes are made between two ticks of a running window, so that an early boundary, a late boundary and a missed boundary each show up as a flag mismatch.

// File: rtl/b2mon_pkg.sv
package b2mon_pkg;
  localparam int DEF_WIN_W = 24;
  localparam int DEF_ACC_W = 16;
  localparam int DEF_CNT_W = 5;
  localparam int NUM_DEFECTS = 2;

  typedef enum logic {
    DEFECT_SD = 1'b0,
    DEFECT_SF = 1'b1
  } defect_e;
endpackage

// File: rtl/b2_win_timer.sv
module b2_win_timer #(
  parameter int WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic [WIN_W-1:0] len_in,
  output logic             win_end,
  output logic             win_idle
);
  logic [WIN_W-1:0] len_q;
  logic [WIN_W-1:0] cnt_q;

  assign win_idle = (len_q == '0);
  assign win_end  = !win_idle && ms_tick && (cnt_q == len_q - 1'b1);

  // The length is captured only at a window start (R9).
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (win_idle || win_end) begin
      len_q <= len_in;
      cnt_q <= '0;
    end else if (ms_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    (len_q != '0) |-> (cnt_q < len_q));

  assert_len_held_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!win_idle) && !$past(win_end)) |-> $stable(len_q));
endmodule

// File: rtl/b2_err_accum.sv
module b2_err_accum #(
  parameter int ACC_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  output logic [ACC_W-1:0] total
);
  localparam int PAD_W = ACC_W + 1 - CNT_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   wide_sum;

  always_comb begin
    wide_sum = {1'b0, acc_q};
    if (add_en) wide_sum = {1'b0, acc_q} + {{PAD_W{1'b0}}, add_val};
    total = wide_sum[ACC_W] ? {ACC_W{1'b1}} : wide_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else            acc_q <= total;
  end

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_q < $past(acc_q)) |-> $past(clr));
endmodule

// File: rtl/b2_defect_fsm.sv
module b2_defect_fsm #(
  parameter int WIN_W = 24,
  parameter int ACC_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_valid,
  input  logic [CNT_W-1:0] err_count,
  input  logic             ms_tick,
  input  logic [WIN_W-1:0] decl_win,
  input  logic [ACC_W-1:0] decl_thr,
  input  logic [WIN_W-1:0] clr_win,
  input  logic [ACC_W-1:0] clr_thr,
  output logic             active,
  output logic             irq
);
  logic             win_end, win_idle;
  logic             next_active;
  logic [WIN_W-1:0] len_sel;
  logic [ACC_W-1:0] total;

  // The next window uses the length that belongs to the state being entered.
  assign len_sel = next_active ? clr_win : decl_win;

  b2_win_timer #(.WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .len_in(len_sel),
    .win_end(win_end), .win_idle(win_idle)
  );

  b2_err_accum #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst(rst), .clr(win_end || win_idle),
    .add_en(err_valid), .add_val(err_count), .total(total)
  );

  always_comb begin
    next_active = active;
    if (win_end) begin
      if (active) next_active = !(total < clr_thr);
      else        next_active = (total > decl_thr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      irq    <= 1'b0;
    end else begin
      active <= next_active;
      irq    <= (next_active != active);
    end
  end

  assert_irq_marks_change_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (active != $past(active)));

  assert_change_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    (active != $past(active)) |-> $past(win_end && ms_tick));

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    $past(win_idle) |-> $stable(active));
endmodule

// File: rtl/b2_defect_monitor.sv
module b2_defect_monitor
  import b2mon_pkg::*;
#(
  parameter int WIN_W = DEF_WIN_W,
  parameter int ACC_W = DEF_ACC_W,
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_valid,
  input  logic [CNT_W-1:0] err_count,
  input  logic             ms_tick,
  input  logic [WIN_W-1:0] sd_decl_win,
  input  logic [ACC_W-1:0] sd_decl_thr,
  input  logic [WIN_W-1:0] sd_clr_win,
  input  logic [ACC_W-1:0] sd_clr_thr,
  input  logic [WIN_W-1:0] sf_decl_win,
  input  logic [ACC_W-1:0] sf_decl_thr,
  input  logic [WIN_W-1:0] sf_clr_win,
  input  logic [ACC_W-1:0] sf_clr_thr,
  output logic             sd_defect,
  output logic             sf_defect,
  output logic             sd_irq,
  output logic             sf_irq
);
  logic [NUM_DEFECTS-1:0] flag_v;
  logic [NUM_DEFECTS-1:0] irq_v;

  for (genvar g = 0; g < NUM_DEFECTS; g++) begin : g_defect
    localparam bit IS_SF = (g == int'(DEFECT_SF));
    b2_defect_fsm #(.WIN_W(WIN_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst(rst),
      .err_valid(err_valid), .err_count(err_count), .ms_tick(ms_tick),
      .decl_win(IS_SF ? sf_decl_win : sd_decl_win),
      .decl_thr(IS_SF ? sf_decl_thr : sd_decl_thr),
      .clr_win (IS_SF ? sf_clr_win  : sd_clr_win),
      .clr_thr (IS_SF ? sf_clr_thr  : sd_clr_thr),
      .active(flag_v[g]), .irq(irq_v[g])
    );
  end

  assign sd_defect = flag_v[DEFECT_SD];
  assign sf_defect = flag_v[DEFECT_SF];
  assign sd_irq    = irq_v[DEFECT_SD];
  assign sf_irq    = irq_v[DEFECT_SF];

  assert_irq_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (flag_v == '0 && irq_v == '0));
endmodule

// File: tb/b2_defect_monitor_test.sv
module b2_defect_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_W = 24;
  localparam int ACC_W = 16;
  localparam int CNT_W = 5;
  localparam int MAX_CNT = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_valid = 1'b0;
  logic [CNT_W-1:0] err_count = '0;
  logic ms_tick = 1'b0;
  logic [WIN_W-1:0] sd_decl_win = 24'd2, sd_clr_win = 24'd3;
  logic [WIN_W-1:0] sf_decl_win = '0, sf_clr_win = '0;
  logic [ACC_W-1:0] sd_decl_thr = 16'd10, sd_clr_thr = 16'd4;
  logic [ACC_W-1:0] sf_decl_thr = 16'd19, sf_clr_thr = 16'd1;
  logic sd_defect, sf_defect, sd_irq, sf_irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  bit exp_sd = 0, exp_sf = 0, exp_sd_irq = 0, exp_sf_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  b2_defect_monitor #(.WIN_W(WIN_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_count(err_count),
    .ms_tick(ms_tick),
    .sd_decl_win(sd_decl_win), .sd_decl_thr(sd_decl_thr),
    .sd_clr_win(sd_clr_win), .sd_clr_thr(sd_clr_thr),
    .sf_decl_win(sf_decl_win), .sf_decl_thr(sf_decl_thr),
    .sf_clr_win(sf_clr_win), .sf_clr_thr(sf_clr_thr),
    .sd_defect(sd_defect), .sf_defect(sf_defect),
    .sd_irq(sd_irq), .sf_irq(sf_irq)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      finish_run();
    end
  end

  // Inputs are applied at a falling edge and held for one clock.
  task automatic step(input bit t, input bit v, input int c);
    ms_tick = t; err_valid = v; err_count = CNT_W'(c);
    @(negedge clk);
    ms_tick = 1'b0; err_valid = 1'b0; err_count = '0;
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual sd=%b sf=%b sdi=%b sfi=%b expected sd=%b sf=%b sdi=%b sfi=%b",
               tag, act[3], act[2], act[1], act[0], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic expect_flags(input string tag, input bit sd, input bit sf);
    exp_sd_irq = (sd != exp_sd);
    exp_sf_irq = (sf != exp_sf);
    exp_sd = sd; exp_sf = sf;
    chk(tag, {sd_defect, sf_defect, sd_irq, sf_irq},
        {exp_sd, exp_sf, exp_sd_irq, exp_sf_irq});
  endtask

  // One window: errors before the ticks, 'last' errors ride on the final tick.
  task automatic run_win(input int len, input int total, input int last);
    int rem = total - last;
    while (rem > 0) begin
      int c = (rem > MAX_CNT) ? MAX_CNT : rem;
      step(0, 1, c);
      rem -= c;
    end
    for (int k = 1; k < len; k++) step(1, 0, 0);
    chk("R5 no change before final tick", {sd_defect, sf_defect, sd_irq, sf_irq},
        {exp_sd, exp_sf, 2'b00});
    step(1, last > 0, last);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1 during reset", {sd_defect, sf_defect, sd_irq, sf_irq}, 4'b0000);
    rst = 1'b0;
    step(0, 0, 0);
    chk("R1 after reset", {sd_defect, sf_defect, sd_irq, sf_irq}, 4'b0000);

    // R2 sweep: totals at and below the declaration threshold.
    for (int tot = 0; tot <= 10; tot += 5) begin
      run_win(2, tot, 0);
      expect_flags("R2 total not above threshold", 0, 0);
    end
    run_win(2, 11, 1);              // R5: one error arrives on the ending tick
    expect_flags("R2 declare at 11 > 10", 1, 0);
    step(0, 0, 0);
    expect_flags("R8 irq lasts one cycle", 1, 0);

    // R3 sweep: clearance needs a total strictly below 4.
    run_win(3, 6, 0);
    expect_flags("R3 total above clear threshold", 1, 0);
    run_win(3, 4, 2);
    expect_flags("R3 total equal to clear threshold", 1, 0);
    run_win(3, 3, 0);
    expect_flags("R3 clear at 3 < 4", 0, 0);

    // R9: shorten the declaration window in the middle of a running window.
    step(1, 0, 0);
    sd_decl_win = 24'd1;
    step(0, 0, 0);
    expect_flags("R9 old length still running", 0, 0);
    step(1, 0, 0);
    expect_flags("R9 window ends at old length", 0, 0);
    run_win(1, 11, 0);
    expect_flags("R9 new length applies next window", 1, 0);
    run_win(3, 0, 0);
    expect_flags("R3 clear on empty window", 0, 0);

    // R7 saturation.
    sd_decl_thr = 16'd65534; sd_clr_win = 24'd1; sd_clr_thr = 16'd5;
    run_win(1, 65544, 0);
    expect_flags("R7 saturated total exceeds 65534", 1, 0);
    run_win(1, 65540, 0);
    expect_flags("R7 saturated total does not wrap below 5", 1, 0);
    run_win(1, 0, 0);
    expect_flags("R3 clear after saturation", 0, 0);

    // Park SD active with its clearance window disabled.
    sd_decl_thr = 16'd10; sd_clr_win = '0;
    run_win(1, 11, 0);
    expect_flags("R2 declare before parking", 1, 0);
    run_win(2, 200, 0);
    expect_flags("R6 disabled clearance window holds SD", 1, 0);

    // SF: disabled declaration window, then real windows (R4, R6, R10).
    run_win(3, 300, 0);
    expect_flags("R6 disabled SF window ignores errors", 1, 0);
    sf_decl_win = 24'd1;
    step(0, 0, 0);
    run_win(1, 19, 0);
    expect_flags("R4 SF equal to threshold", 1, 0);
    run_win(1, 20, 0);
    expect_flags("R4 SF declare, R10 SD untouched", 1, 1);
    run_win(3, 0, 0);
    expect_flags("R6 SF disabled clearance holds", 1, 1);
    sf_clr_win = 24'd2;
    step(0, 0, 0);
    run_win(2, 1, 0);
    expect_flags("R4 SF equal to clear threshold", 1, 1);
    run_win(2, 0, 0);
    expect_flags("R4 SF clear, R10 SD untouched", 1, 0);
    step(0, 0, 0);
    expect_flags("R8 SF irq drops", 1, 0);

    finish_run();
  end
endmodule